// File: doc/BRIEF.md
# Frame Sync Time-Slot Generator

This block turns a free-running bit clock and two frame-start strobes into per-channel frame-sync strobes for a PCM highway. Two frame position counters, one for the transmit direction and one for the receive direction, are restarted by their own start strobe. Each counter walks through 8 bit cycles per slot and up to 64 slots per frame. Each of four transmit and four receive outputs has a configured slot number and an enable bit. An output goes high for exactly the 8 bit cycles of its slot. A combined active-low flag shows that some transmit strobe is high.

The counter is a small state machine with three states. `CNT_IDLE` is the state after reset, before any start strobe. `CNT_RUN` is the state while the frame is being counted. `CNT_HOLD` is the state after the last bit of the last slot. It has four named transitions. START goes from `CNT_IDLE` to `CNT_RUN` on a strobe. RESTART goes from `CNT_RUN` to `CNT_RUN` on a strobe in mid-frame. FRAME_END goes from `CNT_RUN` to `CNT_HOLD` after the last bit. RESUME goes from `CNT_HOLD` to `CNT_RUN` on a strobe.

The `mode_split` input chooses how the receive counter is timed. When it is high, the receive counter follows its own strobe. When it is low, both counters follow the transmit strobe, so every output shares one frame phase.

Top module: `fsync_slot_gen`

## Requirements
- R1: After reset, and until the first start strobe, every `fs_tx` and `fs_rx` bit is 0 and `tx_active_n` is 1.
- R2: The clock cycle in which a start strobe is sampled counts as bit 0 of slot 0. An enabled output assigned to slot 0 is high in the 8 cycles that follow that edge, and low in the cycle after those.
- R3: An enabled output assigned to slot k is high exactly during cycles 8k to 8k+7. Cycles are counted from 0, starting with the cycle that follows the sampling edge of the strobe.
- R4: After cycle 511 the counter holds, and all outputs of that direction stay 0 until the next start strobe.
- R5: A start strobe received in mid-frame restarts the counter at slot 0, bit 0, with no extra delay.
- R6: An output whose enable bit is 0 stays 0 whatever the counter value is.
- R7: When `mode_split`=1, transmit outputs are timed from `tx_sync` and receive outputs from `rx_sync`. The two strobes may have any phase relative to each other.
- R8: When `mode_split`=0, all eight outputs are timed from `tx_sync`, and `rx_sync` has no effect.
- R9: `tx_active_n` is 0 exactly when at least one `fs_tx` bit is 1. Receive strobes do not affect it.
- R10: Channel i takes its slot number from bits [6i+5:6i] of the slot vector for its direction, and its enable from bit i of the enable vector for that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock. All state changes on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_split | input | 1 | 1: independent receive timing. 0: everything timed from `tx_sync` |
| tx_sync | input | 1 | Transmit frame-start strobe, synchronous to `clk` |
| rx_sync | input | 1 | Receive frame-start strobe, used only when `mode_split`=1 |
| tx_slot | input | 24 | Transmit slot numbers. Channel i in bits [6i+5:6i] |
| tx_en | input | 4 | Transmit enables, one bit per channel |
| rx_slot | input | 24 | Receive slot numbers. Channel i in bits [6i+5:6i] |
| rx_en | input | 4 | Receive enables, one bit per channel |
| fs_tx | output | 4 | Transmit frame-sync strobes |
| fs_rx | output | 4 | Receive frame-sync strobes |
| tx_active_n | output | 1 | Low while any transmit strobe is high |

## Verification
A counter with a wrong bit or slot value moves a strobe by whole cycles. That error shows at the first assigned output, within 8 cycles of the fault. A counter stuck in the wrong state either leaves strobes missing after a start strobe, or lets strobes continue past cycle 511. Both show within one frame. A wrong timing source in either mode shifts every receive strobe by the phase offset between the two start strobes. So the bench compares every output on every cycle against a model of the frame position that it keeps itself, and it uses strobes with different phases for the two directions.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_HOLD = 2'd2
    } cnt_state_t;
endpackage

// File: rtl/fsg_frame_counter.sv
module fsg_frame_counter
    import fsg_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int NUM_SLOTS = 64,
    localparam int BIT_W    = $clog2(SLOT_BITS),
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    output cnt_state_t        state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIT_W-1:0]  bit_o
);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    cnt_state_t        state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              frame_last;

    assign frame_last = (bit_q == BIT_LAST) && (slot_q == SLOT_LAST);

    // next-state decode: START, RESTART, FRAME_END, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (sync) state_d = CNT_RUN;
            CNT_RUN:  if (!sync && frame_last) state_d = CNT_HOLD;
            CNT_HOLD: if (sync) state_d = CNT_RUN;
            default:  state_d = CNT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_IDLE;
        else        state_q <= state_d;
    end

    // position registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (sync) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (state_q == CNT_RUN && !frame_last) begin
            if (bit_q == BIT_LAST) begin
                bit_q  <= '0;
                slot_q <= slot_q + 1'b1;
            end else begin
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;
    assign bit_o   = bit_q;

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (state_q == CNT_RUN && slot_q == '0 && bit_q == '0));

    p_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && !sync && bit_q != BIT_LAST)
        |=> (bit_q == $past(bit_q) + 1'b1 && slot_q == $past(slot_q)));

    p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && !sync && bit_q == BIT_LAST && slot_q != SLOT_LAST)
        |=> (bit_q == '0 && slot_q == $past(slot_q) + 1'b1));

    p_hold_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HOLD && !sync) |=> (state_q == CNT_HOLD));
endmodule

// File: rtl/fsg_slot_match.sv
module fsg_slot_match #(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 6
) (
    input  logic                     running,
    input  logic [SLOT_W-1:0]        slot_now,
    input  logic [NUM_CH*SLOT_W-1:0] slot_cfg,
    input  logic [NUM_CH-1:0]        en,
    output logic [NUM_CH-1:0]        fs
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign fs[i] = running && en[i] && (slot_cfg[i*SLOT_W +: SLOT_W] == slot_now);
    end
endmodule

// File: rtl/fsync_slot_gen.sv
module fsync_slot_gen
    import fsg_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SLOT_BITS = 8,
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_split,
    input  logic                     tx_sync,
    input  logic                     rx_sync,
    input  logic [NUM_CH*SLOT_W-1:0] tx_slot,
    input  logic [NUM_CH-1:0]        tx_en,
    input  logic [NUM_CH*SLOT_W-1:0] rx_slot,
    input  logic [NUM_CH-1:0]        rx_en,
    output logic [NUM_CH-1:0]        fs_tx,
    output logic [NUM_CH-1:0]        fs_rx,
    output logic                     tx_active_n
);
    cnt_state_t        tx_state, rx_state;
    logic [SLOT_W-1:0] tx_slot_now, rx_slot_now;
    logic [BIT_W-1:0]  tx_bit_now, rx_bit_now;
    logic              rx_start;

    // shared timing: the receive counter follows the transmit strobe
    assign rx_start = mode_split ? rx_sync : tx_sync;

    fsg_frame_counter #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .sync(tx_sync),
        .state_o(tx_state), .slot_o(tx_slot_now), .bit_o(tx_bit_now)
    );

    fsg_frame_counter #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .sync(rx_start),
        .state_o(rx_state), .slot_o(rx_slot_now), .bit_o(rx_bit_now)
    );

    fsg_slot_match #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_tx_match (
        .running(tx_state == CNT_RUN), .slot_now(tx_slot_now),
        .slot_cfg(tx_slot), .en(tx_en), .fs(fs_tx)
    );

    fsg_slot_match #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_rx_match (
        .running(rx_state == CNT_RUN), .slot_now(rx_slot_now),
        .slot_cfg(rx_slot), .en(rx_en), .fs(fs_rx)
    );

    assign tx_active_n = ~(|fs_tx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (fs_tx == '0 && fs_rx == '0 && tx_active_n);
        end
    end

    p_active_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active_n |-> (tx_state == CNT_RUN));

    p_rx_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state != CNT_RUN) |-> (fs_rx == '0));

    p_shared_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_split && tx_sync)
        |=> (rx_state == CNT_RUN && rx_slot_now == '0 && rx_bit_now == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_en[i] |-> !fs_tx[i]) and (!rx_en[i] |-> !fs_rx[i]));
    end
endmodule

// File: tb/fsync_slot_gen_tb_top.sv
module fsync_slot_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_split = 1'b1;
    logic        tx_sync = 1'b0;
    logic        rx_sync = 1'b0;
    logic [23:0] tx_slot, rx_slot;
    logic [3:0]  tx_en, rx_en;
    logic [3:0]  fs_tx, fs_rx;
    logic        tx_active_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    fsync_slot_gen dut_i (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split),
        .tx_sync(tx_sync), .rx_sync(rx_sync),
        .tx_slot(tx_slot), .tx_en(tx_en),
        .rx_slot(rx_slot), .rx_en(rx_en),
        .fs_tx(fs_tx), .fs_rx(fs_rx), .tx_active_n(tx_active_n)
    );

    // R10 packing: channel i slot in bits [6i+5:6i], enable in bit i
    function automatic logic [3:0] exp_fs(input int k, input logic [23:0] slots,
                                          input logic [3:0] en);
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = en[i] && k >= 0 && k < 512 && (k / 8) == int'(slots[i*6 +: 6]);
        return r;
    endfunction

    function automatic string tag_for(input int k, input string base);
        if (k >= 512) return "R4";
        if (k >= 0 && k < 8) return "R2";
        if (k < 0) return "R1";
        return base;
    endfunction

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp,
                          input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // one scenario: strobes at given cycle offsets, every cycle compared
    task automatic run_scn(input string base, input bit split, input int n,
                           input int txo, input int txo2, input int rxo);
        int tx_k = -1;
        int rx_k = -1;
        mode_split = split;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (t > 0) begin
                logic rx_eff;
                rx_eff = split ? rx_sync : tx_sync;
                if (tx_sync) tx_k = 0; else if (tx_k >= 0) tx_k++;
                if (rx_eff)  rx_k = 0; else if (rx_k >= 0) rx_k++;
                check4(tag_for(tx_k, base), fs_tx, exp_fs(tx_k, tx_slot, tx_en), "fs_tx");
                check4(tag_for(rx_k, base), fs_rx, exp_fs(rx_k, rx_slot, rx_en), "fs_rx");
                check4("R9", {3'b0, tx_active_n},
                       {3'b0, ~(|exp_fs(tx_k, tx_slot, tx_en))}, "tx_active_n");
            end
            tx_sync = (t == txo) || (t == txo2);
            rx_sync = (t == rxo);
        end
        tx_sync = 1'b0;
        rx_sync = 1'b0;
    endtask

    task automatic test_reset;
        @(negedge clk);
        check4("R1", fs_tx, 4'b0, "fs_tx in reset");
        check4("R1", fs_rx, 4'b0, "fs_rx in reset");
        check4("R1", {3'b0, tx_active_n}, 4'b1, "tx_active_n in reset");
        rst_n = 1'b1;
        run_scn("R1", 1'b1, 20, -1, -1, -1);
    endtask

    task automatic test_aligned;   // R3, same phase both directions
        run_scn("R3", 1'b1, 530, 0, -1, 0);
    endtask

    task automatic test_phased;    // R7, different phases
        run_scn("R7", 1'b1, 570, 2, -1, 40);
    endtask

    task automatic test_restart;   // R5, second strobe mid-frame
        run_scn("R5", 1'b1, 640, 0, 100, 3);
    endtask

    task automatic test_shared;    // R8, rx_sync ignored
        run_scn("R8", 1'b0, 560, 5, -1, 30);
    endtask

    task automatic test_disabled;  // R6, all enables cleared
        tx_en = 4'b0000;
        rx_en = 4'b0000;
        run_scn("R6", 1'b1, 530, 0, -1, 7);
        tx_en = 4'b0111;
        rx_en = 4'b1011;
    endtask

    initial begin
        tx_slot = {6'd10, 6'd63, 6'd5, 6'd0};
        tx_en   = 4'b0111;
        rx_slot = {6'd20, 6'd63, 6'd0, 6'd3};
        rx_en   = 4'b1011;
        repeat (3) @(posedge clk);
        test_reset();
        test_aligned();
        test_phased();
        test_restart();
        test_shared();
        test_disabled();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule